// File: doc/BRIEF.md
# Nested priority interrupt controller

This block sits beside a processor core and decides which exception, if any, may interrupt the code running now. It watches a parameterised set of external interrupt lines together with a non-maskable input and a fault input, records rising edges as pending, and keeps an active bit per source while its handler runs. From the active handlers and three mask settings it derives a running priority level. It raises a request carrying the exception number of the best pending source whenever that source outranks the running level.

The core answers with an acknowledge strobe, which turns the winner from pending into active. When a handler returns, the core sends a completion strobe with the handler's exception number, which clears its active bit. A single write port programs per-line priorities, per-line enables, a global mask bit, a fault mask bit and a base-priority threshold. Writes can happen at any time and take effect on the next cycle.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A rising edge on a source sets its pending bit at the next clock edge. An enabled, unmasked pending source is then requested with exception number 2 for the non-maskable input, 3 for the fault input and 16+n for external line n.
- R2: A pending source is requested only if its priority is strictly higher, meaning numerically lower, than the running priority. Equal priority never preempts.
- R3: The non-maskable input has fixed priority -2 and the fault input has fixed priority -1. Both outrank every programmable level, including 0.
- R4: Among pending sources of equal priority, the one with the lower exception number wins.
- R5: The running priority is the highest priority among active handlers. With no handler active it is one step below the lowest programmable level, so after reset any enabled pending line is requested.
- R6: A source whose handler is active is never requested again until its completion strobe arrives, even if its priority is raised meanwhile.
- R7: While the global mask bit (write kind 2, data bit 0) is set, only the non-maskable and fault inputs can be requested.
- R8: While the fault mask bit (write kind 3, data bit 0) is set, only the non-maskable input can be requested.
- R9: A nonzero threshold T (write kind 4, data bits PRIO_BITS-1:0) blocks every line whose priority is T or numerically greater. T = 0 masks nothing.
- R10: A pending, inactive non-maskable input is always requested, whatever the masks and the active handlers.
- R11: An acknowledge while a request is shown clears that source's pending bit and makes it active. A completion strobe with an exception number clears that source's active bit.
- R12: Line n is requested only while its enable (write kind 1, index n, data bit 0) is set. Enables reset to 0. A line that is disabled still records its edge, so it is requested once it is enabled.
- R13: A priority write (write kind 0, index n, data bits PRIO_BITS-1:0) changes arbitration from the next cycle, also for lines that are already pending. All priorities reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_line | input | NUM_IRQ | External interrupt lines, edge sensitive |
| nmi_in | input | 1 | Non-maskable input, edge sensitive |
| fault_in | input | 1 | Fault input, edge sensitive |
| req_valid | output | 1 | A source may preempt now |
| req_num | output | 8 | Exception number of the requested source |
| req_ack | input | 1 | Core takes the shown request |
| done_strobe | input | 1 | Core finished a handler |
| done_num | input | 8 | Exception number of the finished handler |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 3 | Write target: 0 priority, 1 enable, 2 global mask, 3 fault mask, 4 threshold |
| cfg_idx | input | IDX_W | Line index for priority and enable writes |
| cfg_data | input | 8 | Write data |

## Verification
Every pair of external lines is raised together under three priority patterns. One pattern gives both lines equal priority, which isolates the tie-break on exception number. The other two give mixed priorities, which show that strict preemption is separate from ordering. Directed sequences nest handlers at equal and at higher priority to separate the running-level rule from plain arbitration. They raise a line's priority while its handler is active to expose re-entry, and they drive the non-maskable and fault inputs under each mask to show that the three masks cut at different levels. Each step is compared against an arithmetic model of pending, active and running priority kept inside the bench.

// File: rtl/pic_pkg.sv
package pic_pkg;
  // Internal rank: smaller is more urgent. Programmable level p maps to p+3.
  typedef logic [9:0] rank_t;

  typedef enum logic [2:0] {
    WK_PRIO   = 3'd0,
    WK_EN     = 3'd1,
    WK_GMASK  = 3'd2,
    WK_FMASK  = 3'd3,
    WK_THRESH = 3'd4
  } cfg_kind_e;

  localparam rank_t RANK_NMI   = 10'd1;
  localparam rank_t RANK_FAULT = 10'd2;
  localparam int    FIXED_SRC  = 2;

  function automatic rank_t prog_rank(input logic [7:0] p);
    return rank_t'(p) + rank_t'(3);
  endfunction

  function automatic logic [7:0] src_to_num(input int s);
    if (s == 0) return 8'd2;
    if (s == 1) return 8'd3;
    return 8'(s + 14);
  endfunction
endpackage

// File: rtl/pic_cfg.sv
module pic_cfg
  import pic_pkg::*;
#(
  parameter int NUM_IRQ   = 8,
  parameter int PRIO_BITS = 3,
  parameter int IDX_W     = 3
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                we,
  input  logic [2:0]                          kind,
  input  logic [IDX_W-1:0]                    idx,
  input  logic [7:0]                          data,
  output logic [NUM_IRQ-1:0][PRIO_BITS-1:0]   prio,
  output logic [NUM_IRQ-1:0]                  en,
  output logic                                gmask,
  output logic                                fmask,
  output logic [PRIO_BITS-1:0]                thresh
);
  logic idx_ok;
  assign idx_ok = (int'(idx) < NUM_IRQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio   <= '0;
      en     <= '0;
      gmask  <= 1'b0;
      fmask  <= 1'b0;
      thresh <= '0;
    end else if (we) begin
      case (cfg_kind_e'(kind))
        WK_PRIO:   if (idx_ok) prio[idx] <= data[PRIO_BITS-1:0];
        WK_EN:     if (idx_ok) en[idx] <= data[0];
        WK_GMASK:  gmask <= data[0];
        WK_FMASK:  fmask <= data[0];
        WK_THRESH: thresh <= data[PRIO_BITS-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pic_src_state.sv
module pic_src_state #(
  parameter int NSRC = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic [NSRC-1:0] ack_hit,
  input  logic [NSRC-1:0] done_hit,
  output logic [NSRC-1:0] pend,
  output logic [NSRC-1:0] act
);
  logic [NSRC-1:0] src_q;
  logic [NSRC-1:0] rise;

  assign rise = src_in & ~src_q;

  always_ff @(posedge clk) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_in;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[i] <= 1'b0;
        act[i]  <= 1'b0;
      end else begin
        pend[i] <= (pend[i] & ~ack_hit[i]) | rise[i];
        act[i]  <= (act[i] | ack_hit[i]) & ~done_hit[i];
      end
    end

    assert_edge_pends_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rise[i] |=> pend[i]);
    assert_ack_activates_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit[i] && !done_hit[i]) |=> act[i]);
    assert_done_retires_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done_hit[i] |=> !act[i]);
  end
endmodule

// File: rtl/pic_run_level.sv
module pic_run_level
  import pic_pkg::*;
#(
  parameter int NSRC      = 10,
  parameter int PRIO_BITS = 3
) (
  input  logic [NSRC-1:0]        act,
  input  rank_t [NSRC-1:0]       rank,
  input  logic                   gmask,
  input  logic                   fmask,
  input  logic [PRIO_BITS-1:0]   thresh,
  output rank_t                  run_rank
);
  localparam rank_t BASE_RANK = rank_t'((2 ** PRIO_BITS) + 3);

  always_comb begin
    run_rank = BASE_RANK;
    for (int i = 0; i < NSRC; i++)
      if (act[i] && rank[i] < run_rank) run_rank = rank[i];
    if (thresh != '0 && prog_rank(8'(thresh)) < run_rank) run_rank = prog_rank(8'(thresh));
    if (gmask && prog_rank(8'd0) < run_rank) run_rank = prog_rank(8'd0);
    if (fmask && RANK_FAULT < run_rank) run_rank = RANK_FAULT;
  end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
  import pic_pkg::*;
#(
  parameter int NSRC  = 10,
  parameter int SRC_W = 4
) (
  input  logic [NSRC-1:0]  elig,
  input  rank_t [NSRC-1:0] rank,
  output logic             found,
  output logic [SRC_W-1:0] win_idx,
  output rank_t            win_rank
);
  // Ascending scan with strict compare keeps the lowest index on ties.
  always_comb begin
    found    = 1'b0;
    win_idx  = '0;
    win_rank = '1;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && (!found || rank[i] < win_rank)) begin
        found    = 1'b1;
        win_idx  = SRC_W'(i);
        win_rank = rank[i];
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_IRQ   = 8,
  parameter int PRIO_BITS = 3,
  parameter int IDX_W     = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_line,
  input  logic               nmi_in,
  input  logic               fault_in,
  output logic               req_valid,
  output logic [7:0]         req_num,
  input  logic               req_ack,
  input  logic               done_strobe,
  input  logic [7:0]         done_num,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_kind,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [7:0]         cfg_data
);
  localparam int NSRC  = NUM_IRQ + FIXED_SRC;
  localparam int SRC_W = $clog2(NSRC);

  logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prio;
  logic [NUM_IRQ-1:0]                irq_en;
  logic                              gmask, fmask;
  logic [PRIO_BITS-1:0]              thresh;

  logic [NSRC-1:0]  src_in, pend, act, en_vec, elig, ack_hit, done_hit;
  rank_t [NSRC-1:0] rank;
  rank_t            run_rank, win_rank;
  logic             found;
  logic [SRC_W-1:0] win_idx;

  pic_cfg #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .kind(cfg_kind), .idx(cfg_idx),
    .data(cfg_data), .prio(prio), .en(irq_en), .gmask(gmask), .fmask(fmask),
    .thresh(thresh)
  );

  assign src_in = {irq_line, fault_in, nmi_in};
  assign en_vec = {irq_en, 2'b11};

  for (genvar i = 0; i < NSRC; i++) begin : g_rank
    if (i == 0) begin : g_nmi
      assign rank[i] = RANK_NMI;
    end else if (i == 1) begin : g_fault
      assign rank[i] = RANK_FAULT;
    end else begin : g_line
      assign rank[i] = prog_rank(8'(prio[i-FIXED_SRC]));
    end
  end

  pic_src_state #(.NSRC(NSRC)) u_state (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .ack_hit(ack_hit),
    .done_hit(done_hit), .pend(pend), .act(act)
  );

  assign elig = pend & ~act & en_vec;

  pic_run_level #(.NSRC(NSRC), .PRIO_BITS(PRIO_BITS)) u_run (
    .act(act), .rank(rank), .gmask(gmask), .fmask(fmask), .thresh(thresh),
    .run_rank(run_rank)
  );

  pic_arbiter #(.NSRC(NSRC), .SRC_W(SRC_W)) u_arb (
    .elig(elig), .rank(rank), .found(found), .win_idx(win_idx), .win_rank(win_rank)
  );

  assign req_valid = found && (win_rank < run_rank);
  assign req_num   = src_to_num(int'(win_idx));

  always_comb begin
    ack_hit = '0;
    if (req_ack && req_valid) ack_hit[win_idx] = 1'b1;
  end

  always_comb begin
    done_hit = '0;
    if (done_strobe) begin
      if (done_num == 8'd2)      done_hit[0] = 1'b1;
      else if (done_num == 8'd3) done_hit[1] = 1'b1;
      else
        for (int i = 0; i < NUM_IRQ; i++)
          if (done_num == 8'(16 + i)) done_hit[i+FIXED_SRC] = 1'b1;
    end
  end

  assert_no_reentry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !act[win_idx]);
  assert_gmask_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gmask && req_valid) |-> (req_num == 8'd2 || req_num == 8'd3));
  assert_fmask_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fmask && req_valid) |-> (req_num == 8'd2));
  assert_thresh_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (thresh != '0 && req_valid && req_num >= 8'd16) |-> (win_rank < prog_rank(8'(thresh))));
  assert_nmi_taken_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[0] && !act[0]) |-> (req_valid && req_num == 8'd2));
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  localparam int NUM_IRQ = 8;
  localparam int PB      = 3;
  localparam int NSRC    = NUM_IRQ + 2;
  localparam int BASE    = 2 ** PB;

  logic               clk = 1'b0;
  logic               rst_n;
  logic [NUM_IRQ-1:0] irq_line;
  logic               nmi_in, fault_in, req_ack, done_strobe, cfg_we;
  logic [7:0]         done_num, cfg_data, req_num;
  logic [2:0]         cfg_kind;
  logic [2:0]         cfg_idx;
  logic               req_valid;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // model state; priorities held as signed levels (-2 NMI, -1 fault)
  int m_prio [NUM_IRQ];
  bit m_en   [NUM_IRQ];
  bit m_pend [NSRC];
  bit m_act  [NSRC];
  bit m_prev [NSRC];
  bit m_gm, m_fm;
  int m_th;

  always #2 clk = ~clk;

  prio_irq_ctrl #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PB)) u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .nmi_in(nmi_in),
    .fault_in(fault_in), .req_valid(req_valid), .req_num(req_num),
    .req_ack(req_ack), .done_strobe(done_strobe), .done_num(done_num),
    .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx), .cfg_data(cfg_data)
  );

  function automatic int level_of(int s);
    if (s == 0) return -2;
    if (s == 1) return -1;
    return m_prio[s-2];
  endfunction

  function automatic int num_of(int s);
    if (s == 0) return 2;
    if (s == 1) return 3;
    return s + 14;
  endfunction

  function automatic void model_eval(output bit v, output int w);
    int run = BASE;
    int best = 1000;
    w = -1;
    for (int s = 0; s < NSRC; s++) if (m_act[s] && level_of(s) < run) run = level_of(s);
    if (m_th != 0 && m_th < run) run = m_th;
    if (m_gm && 0 < run) run = 0;
    if (m_fm && -1 < run) run = -1;
    for (int s = 0; s < NSRC; s++)
      if (m_pend[s] && !m_act[s] && (s < 2 || m_en[s-2]) && level_of(s) < best) begin
        best = level_of(s);
        w = s;
      end
    v = (w >= 0) && (best < run);
  endfunction

  task automatic tick(input string tag);
    bit v;
    int w;
    bit cur [NSRC];
    model_eval(v, w);
    cur[0] = nmi_in;
    cur[1] = fault_in;
    for (int i = 0; i < NUM_IRQ; i++) cur[i+2] = irq_line[i];
    if (req_ack && v) begin m_pend[w] = 0; m_act[w] = 1; end
    for (int s = 0; s < NSRC; s++) begin
      if (cur[s] && !m_prev[s]) m_pend[s] = 1;
      m_prev[s] = cur[s];
    end
    if (done_strobe)
      for (int s = 0; s < NSRC; s++) if (num_of(s) == int'(done_num)) m_act[s] = 0;
    if (cfg_we) begin
      case (cfg_kind)
        3'd0: m_prio[cfg_idx] = int'(cfg_data[PB-1:0]);
        3'd1: m_en[cfg_idx]   = cfg_data[0];
        3'd2: m_gm = cfg_data[0];
        3'd3: m_fm = cfg_data[0];
        3'd4: m_th = int'(cfg_data[PB-1:0]);
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    model_eval(v, w);
    vectors++;
    if (req_valid !== v || (v && int'(req_num) != num_of(w))) begin
      miscompares++;
      $display("FAIL %s: got valid=%0b num=%0d, expected valid=%0b num=%0d",
               tag, req_valid, req_num, v, v ? num_of(w) : 0);
    end
  endtask

  task automatic cfg(input int kind, input int idx, input int data, input string tag);
    cfg_we = 1; cfg_kind = 3'(kind); cfg_idx = 3'(idx); cfg_data = 8'(data);
    tick(tag);
    cfg_we = 0;
  endtask

  task automatic ack(input string tag);
    req_ack = 1; tick(tag); req_ack = 0;
  endtask

  task automatic done(input int num, input string tag);
    done_strobe = 1; done_num = 8'(num); tick(tag); done_strobe = 0;
  endtask

  task automatic drain_pair(input int i, input int j);
    for (int k = 0; k < 3; k++) begin
      ack("R11 pair ack");
      done(16 + i, "R11 pair done");
      done(16 + j, "R11 pair done");
    end
  endtask

  initial begin
    #800000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 0; irq_line = '0; nmi_in = 0; fault_in = 0; req_ack = 0;
    done_strobe = 0; done_num = '0; cfg_we = 0; cfg_kind = '0; cfg_idx = '0; cfg_data = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin m_prio[i] = 0; m_en[i] = 0; end
    for (int s = 0; s < NSRC; s++) begin m_pend[s] = 0; m_act[s] = 0; m_prev[s] = 0; end
    m_gm = 0; m_fm = 0; m_th = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick("R5 reset idle");

    // R12: disabled line records its edge but is not requested
    irq_line[7] = 1; tick("R12 disabled line");
    cfg(1, 7, 1, "R12 enable releases");
    ack("R11 ack"); irq_line[7] = 0; done(23, "R11 done");

    // R1: every line alone, numbering and handshake
    for (int n = 0; n < NUM_IRQ; n++) begin
      cfg(0, n, 7 - n, "R13 prio write");
      cfg(1, n, 1, "R12 enable");
    end
    for (int n = 0; n < NUM_IRQ; n++) begin
      irq_line[n] = 1; tick("R1 single line");
      ack("R11 ack single");
      irq_line[n] = 0; tick("R1 line low");
      done(16 + n, "R11 done single");
    end

    // R4 and R2: every pair under three priority patterns
    for (int pat = 0; pat < 3; pat++)
      for (int i = 0; i < NUM_IRQ; i++)
        for (int j = i + 1; j < NUM_IRQ; j++) begin
          cfg(0, i, (pat == 0) ? 2 : (i * 3 + pat) % BASE, "R4 pair prio");
          cfg(0, j, (pat == 0) ? 2 : (j * 5 + pat * 2) % BASE, "R4 pair prio");
          irq_line[i] = 1; irq_line[j] = 1; tick("R4 pair raise");
          drain_pair(i, j);
          irq_line[i] = 0; irq_line[j] = 0; tick("R2 pair low");
        end

    // R2 and R5: nesting at equal and higher priority
    cfg(0, 3, 5, "R13"); cfg(0, 1, 5, "R13"); cfg(0, 2, 4, "R13");
    irq_line[3] = 1; tick("R5 base level"); ack("R11");
    irq_line[1] = 1; tick("R2 equal no preempt");
    irq_line[2] = 1; tick("R2 higher preempts"); ack("R11");
    done(18, "R5 back to active level");
    done(19, "R5 next pending taken");
    ack("R11"); done(17, "R11");
    irq_line = '0; tick("R5 idle");

    // R6: raised priority while active does not re-enter
    cfg(0, 0, 6, "R13");
    irq_line[0] = 1; tick("R1"); ack("R11"); irq_line[0] = 0; tick("R6 low");
    cfg(0, 0, 0, "R6 raise prio while active");
    irq_line[0] = 1; tick("R6 no reentry");
    done(16, "R6 pending after completion");
    ack("R11"); done(16, "R11"); irq_line[0] = 0; tick("R6 idle");

    // R7, R3, R10: global mask
    cfg(0, 4, 0, "R13");
    cfg(2, 0, 1, "R7 set global mask");
    irq_line[4] = 1; tick("R7 line blocked");
    fault_in = 1; tick("R3 fault passes global mask"); ack("R11");
    nmi_in = 1; tick("R10 nmi preempts fault"); ack("R11");
    done(2, "R11"); done(3, "R7 still blocked");
    cfg(2, 0, 0, "R7 clear global mask");
    ack("R11"); done(20, "R11");
    irq_line[4] = 0; fault_in = 0; nmi_in = 0; tick("R7 idle");

    // R8, R10, R3: fault mask
    cfg(3, 0, 1, "R8 set fault mask");
    fault_in = 1; tick("R8 fault blocked");
    nmi_in = 1; tick("R10 nmi ignores masks"); ack("R11"); done(2, "R8");
    cfg(3, 0, 0, "R8 clear fault mask");
    ack("R11"); done(3, "R11");
    fault_in = 0; nmi_in = 0; tick("R8 idle");

    // R3: fault beats programmable level 0
    fault_in = 1; irq_line[4] = 1; tick("R3 fault over level 0");
    ack("R11"); done(3, "R11"); ack("R11"); done(20, "R11");
    fault_in = 0; irq_line[4] = 0; tick("R3 idle");

    // R9: threshold
    cfg(0, 5, 4, "R13"); cfg(0, 6, 3, "R13");
    cfg(4, 0, 4, "R9 threshold 4");
    irq_line[5] = 1; tick("R9 equal level blocked");
    irq_line[6] = 1; tick("R9 higher level passes"); ack("R11"); done(22, "R9");
    cfg(4, 0, 0, "R9 zero disables");
    ack("R11"); done(21, "R11");
    irq_line = '0; tick("R9 idle");

    // R13: priority rewrite of pending lines
    cfg(0, 1, 5, "R13"); cfg(0, 2, 6, "R13");
    irq_line[1] = 1; irq_line[2] = 1; tick("R13 before rewrite");
    cfg(0, 2, 1, "R13 rewrite changes winner");
    drain_pair(1, 2);
    irq_line = '0; tick("R13 idle");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule